// File: doc/BRIEF.md
# Trace-Based Spike-Timing Plasticity Weight Engine

This block maintains the plastic input weights of one spiking neuron. Each plastic synapse owns a weight and a presynaptic activity trace, kept together in one word of an external synapse memory. The neuron's postsynaptic trace is kept in a register inside the block. A presynaptic spike raises that synapse's trace and moves its weight by the postsynaptic trace. A postsynaptic spike applies a negative step to the postsynaptic trace and moves every plastic weight by its own presynaptic trace. After every update the weight is held between zero and a maximum.

A time-step tick makes every trace decay by a right-shift fraction of itself. A normalization command, issued between training samples, adds a common correction to every plastic weight. The correction is the difference between a target and the current weight sum, divided by the synapse count. Synapse indices above the plastic range belong to fixed teacher inputs, and the block never touches them.

The memory is simple dual-port: one read and one write per cycle, with one cycle of read latency. The block walks the synapses one per cycle and raises `busy` for the whole of each operation.

Top module: `stdp_weight_engine`

## Requirements
- R1: Out of reset, `busy` is low, `post_trace` is 0, and no memory read or write is issued while the block is idle.
- R2: An accepted presynaptic spike on plastic index s reads word s one cycle after acceptance and writes it back one cycle later. In that word the trace gains DPRE, saturating at 2^TW−1, and the weight gains `post_trace`. `busy` is high for exactly 2 cycles.
- R3: An accepted postsynaptic spike adds DPOST (negative) to `post_trace`, saturating at −2^(TW−1), so `post_trace` is never positive. Every plastic weight gains its own presynaptic trace. `busy` is high for N_PLAST+1 cycles.
- R4: Every weight written is clamped to the range 0 to WMAX.
- R5: A tick decays `post_trace` by p − (p >>> POST_SHIFT) (arithmetic shift) and every presynaptic trace by a − (a >> PRE_SHIFT). Weights are unchanged. A tick is served whatever the value of `learn_en`, and `busy` is high for N_PLAST+1 cycles.
- R6: A normalization command adds fac = (TARGET − Σw) / N_PLAST, truncated toward zero, to every plastic weight and clamps the result. Traces are unchanged. `busy` is high for 2·N_PLAST+2+SW cycles, where SW = WW+clog2(N_PLAST+1)+1.
- R7: With `learn_en` low, presynaptic spikes, postsynaptic spikes and normalization commands are ignored.
- R8: A presynaptic spike whose index is N_PLAST or above (a teacher synapse) is ignored, and its word is never accessed.
- R9: Requests taken in one idle cycle follow the priority tick, then normalize, then post spike, then pre spike. Requests that arrive while `busy` is high are dropped.
- R10: A memory word holds the weight in bits [WW−1:0] and the presynaptic trace in bits [WW+TW−1:WW]. Each write goes to the address read in the previous cycle, so the engine handles one synapse per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| learn_en | input | 1 | Enables plasticity and normalization |
| tick | input | 1 | Time-step pulse that starts trace decay |
| pre_spike | input | 1 | Presynaptic spike pulse |
| pre_idx | input | IW | Synapse index of the presynaptic spike |
| post_spike | input | 1 | Postsynaptic spike pulse |
| norm_req | input | 1 | Normalization command |
| busy | output | 1 | High while an operation is running |
| post_trace | output | TW | Signed postsynaptic trace |
| rd_en | output | 1 | Synapse memory read enable |
| rd_addr | output | AW | Synapse memory read address |
| rd_data | input | MW | Read data, valid one cycle after `rd_en` |
| wr_en | output | 1 | Synapse memory write enable |
| wr_addr | output | AW | Synapse memory write address |
| wr_data | output | MW | Write data: trace in the high field, weight in the low field |

## Verification
Take a request driven before edge E0. `busy` rises after E0. A single-synapse update lands in memory at E0+2, a full sweep at E0+N_PLAST+1, and a normalization at E0+2·N_PLAST+2+SW. `post_trace` changes at E0 itself. The bench drives every request on a falling edge and removes it on the next one. It then counts the falling edges on which `busy` is high and compares that count with the cycle totals in the requirements. It compares the memory and `post_trace` with an arithmetic model only once `busy` has dropped, so every write has landed before the check. Ignored requests are checked on the falling edge right after the request: `busy` must be low there, and the memory must still match the model.

// File: rtl/stdp_weight_engine.sv
module stdp_weight_engine #(
  parameter int N_PLAST    = 8,
  parameter int N_SYN      = 10,
  parameter int WW         = 16,
  parameter int TW         = 16,
  parameter int WMAX       = 1000,
  parameter int DPRE       = 100,
  parameter int DPOST      = -60,
  parameter int PRE_SHIFT  = 3,
  parameter int POST_SHIFT = 2,
  parameter int TARGET     = 4000,
  localparam int IW = $clog2(N_SYN),
  localparam int AW = $clog2(N_PLAST),
  localparam int MW = WW + TW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 learn_en,
  input  logic                 tick,
  input  logic                 pre_spike,
  input  logic [IW-1:0]        pre_idx,
  input  logic                 post_spike,
  input  logic                 norm_req,
  output logic                 busy,
  output logic signed [TW-1:0] post_trace,
  output logic                 rd_en,
  output logic [AW-1:0]        rd_addr,
  input  logic [MW-1:0]        rd_data,
  output logic                 wr_en,
  output logic [AW-1:0]        wr_addr,
  output logic [MW-1:0]        wr_data
);
  localparam int CW  = $clog2(N_PLAST + 1);
  localparam int SW  = WW + CW + 1;
  localparam int EW  = WW + TW + CW + 3;
  localparam int DCW = $clog2(SW);
  localparam logic [CW:0]            NDIV    = (CW+1)'(N_PLAST);
  localparam logic [TW:0]            DPRE_X  = (TW+1)'(DPRE);
  localparam logic signed [TW:0]     DPOST_X = (TW+1)'(DPOST);
  localparam logic signed [TW:0]     AMIN    = {2'b11, {(TW-1){1'b0}}};
  localparam logic signed [EW-1:0]   WMAX_X  = EW'(WMAX);
  localparam logic signed [SW:0]     TGT_X   = (SW+1)'(TARGET);
  localparam logic [IW-1:0]          NP_I    = IW'(N_PLAST);
  localparam logic [AW-1:0]          LAST_A  = AW'(N_PLAST - 1);
  localparam logic [DCW-1:0]         DLAST   = DCW'(SW - 1);

  typedef enum logic [1:0] {S_IDLE, S_SWEEP, S_DIV} st_t;
  typedef enum logic [2:0] {M_PRE, M_POST, M_DECAY, M_SUM, M_NORM} md_t;

  st_t st;
  md_t md;
  logic [AW-1:0]        rcnt, rlast, idx1;
  logic                 rstop, v1, neg;
  logic [SW-1:0]        acc, quo;
  logic [CW-1:0]        rem;
  logic [DCW-1:0]       dcnt;
  logic signed [SW:0]   fac;
  logic signed [TW-1:0] apost;

  logic [WW-1:0] w_in;
  logic [TW-1:0] a_in;
  assign w_in = rd_data[WW-1:0];
  assign a_in = rd_data[MW-1:WW];

  assign busy       = st != S_IDLE;
  assign post_trace = apost;
  assign rd_en      = (st == S_SWEEP) && !rstop;
  assign rd_addr    = rcnt;
  assign wr_en      = (st == S_SWEEP) && v1 && (md != M_SUM);
  assign wr_addr    = idx1;

  logic signed [EW-1:0] delta, wsum;
  logic [WW-1:0] wcl, w_out;
  logic [TW:0]   apre_inc;
  logic [TW-1:0] apre_sat, a_dec, a_out;

  always_comb begin
    case (md)
      M_PRE:   delta = EW'(apost);
      M_POST:  delta = $signed(EW'(a_in));
      M_NORM:  delta = EW'(fac);
      default: delta = '0;
    endcase
  end

  assign wsum     = $signed(EW'(w_in)) + delta;
  assign wcl      = (wsum < 0) ? '0 : (wsum > WMAX_X) ? WW'(WMAX) : wsum[WW-1:0];
  assign apre_inc = {1'b0, a_in} + DPRE_X;
  assign apre_sat = apre_inc[TW] ? '1 : apre_inc[TW-1:0];
  assign a_dec    = a_in - (a_in >> PRE_SHIFT);
  assign a_out    = (md == M_PRE) ? apre_sat : (md == M_DECAY) ? a_dec : a_in;
  assign w_out    = (md == M_DECAY) ? w_in : wcl;
  assign wr_data  = {a_out, w_out};

  logic signed [TW:0]   post_sum;
  logic signed [TW-1:0] post_sat, post_dec;
  assign post_sum = $signed({apost[TW-1], apost}) + DPOST_X;
  assign post_sat = (post_sum < AMIN) ? AMIN[TW-1:0] : post_sum[TW-1:0];
  assign post_dec = apost - (apost >>> POST_SHIFT);

  logic [SW-1:0]      sum_fin, mag, quo_n;
  logic signed [SW:0] diff, fac_n;
  logic [CW:0]        trial, tsub;
  logic               ge;
  logic [CW-1:0]      rem_n;
  assign sum_fin = acc + SW'(w_in);
  assign diff    = TGT_X - $signed({1'b0, sum_fin});
  assign mag     = diff[SW] ? SW'(-diff) : diff[SW-1:0];
  assign trial   = {rem, quo[SW-1]};
  assign tsub    = trial - NDIV;
  assign ge      = trial >= NDIV;
  assign rem_n   = ge ? tsub[CW-1:0] : trial[CW-1:0];
  assign quo_n   = {quo[SW-2:0], ge};
  assign fac_n   = neg ? -$signed({1'b0, quo_n}) : $signed({1'b0, quo_n});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  md <= M_DECAY;
      rcnt <= '0;  rlast <= '0;  idx1 <= '0;
      rstop <= 1'b1;  v1 <= 1'b0;  neg <= 1'b0;
      acc <= '0;  quo <= '0;  rem <= '0;  dcnt <= '0;
      fac <= '0;  apost <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          v1 <= 1'b0;  rstop <= 1'b0;  rcnt <= '0;  rlast <= LAST_A;
          if (tick) begin
            st <= S_SWEEP;  md <= M_DECAY;  apost <= post_dec;
          end else if (learn_en && norm_req) begin
            st <= S_SWEEP;  md <= M_SUM;  acc <= '0;
          end else if (learn_en && post_spike) begin
            st <= S_SWEEP;  md <= M_POST;  apost <= post_sat;
          end else if (learn_en && pre_spike && pre_idx < NP_I) begin
            st <= S_SWEEP;  md <= M_PRE;
            rcnt <= pre_idx[AW-1:0];  rlast <= pre_idx[AW-1:0];
          end
        end
        S_SWEEP: begin
          v1   <= rd_en;
          idx1 <= rcnt;
          if (rd_en) begin
            rcnt <= rcnt + 1'b1;
            if (rcnt == rlast) rstop <= 1'b1;
          end
          if (v1 && md == M_SUM) acc <= sum_fin;
          if (v1 && idx1 == rlast) begin
            if (md == M_SUM) begin
              st <= S_DIV;  dcnt <= '0;  rem <= '0;
              neg <= diff[SW];  quo <= mag;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_DIV: begin
          rem  <= rem_n;
          quo  <= quo_n;
          dcnt <= dcnt + 1'b1;
          if (dcnt == DLAST) begin
            fac <= fac_n;  st <= S_SWEEP;  md <= M_NORM;
            rcnt <= '0;  rstop <= 1'b0;  v1 <= 1'b0;  rlast <= LAST_A;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stdp_weight_engine_chk.sv
module stdp_weight_engine_chk #(
  parameter int AW   = 3,
  parameter int MW   = 32,
  parameter int WW   = 16,
  parameter int TW   = 16,
  parameter int WMAX = 1000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 learn_en,
  input logic                 tick,
  input logic                 busy,
  input logic signed [TW-1:0] post_trace,
  input logic                 rd_en,
  input logic [AW-1:0]        rd_addr,
  input logic                 wr_en,
  input logic [AW-1:0]        wr_addr,
  input logic [MW-1:0]        wr_data
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_en && !wr_en));
  // R3
  post_nonpos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_trace <= 0);
  // R4
  weight_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data[WW-1:0] <= WW'(WMAX)));
  // R5
  tick_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tick) |=> busy);
  // R7
  learn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tick && !learn_en) |=> !busy);
  // R10
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(rd_en) && wr_addr == $past(rd_addr)));
endmodule

bind stdp_weight_engine stdp_weight_engine_chk #(
  .AW(AW), .MW(MW), .WW(WW), .TW(TW), .WMAX(WMAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .learn_en(learn_en), .tick(tick), .busy(busy),
  .post_trace(post_trace), .rd_en(rd_en), .rd_addr(rd_addr),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/stdp_weight_engine_bench.sv
module stdp_weight_engine_bench;
  localparam int N = 8, NS = 10, WMAX = 1000, DPRE = 100, DPOST = -60;
  localparam int PSH = 3, QSH = 2, TGT = 4000;
  localparam int SWB = 16 + $clog2(N + 1) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic learn_en = 1'b1, tick = 1'b0, pre_spike = 1'b0, post_spike = 1'b0, norm_req = 1'b0;
  logic [3:0] pre_idx = '0;
  logic busy, rd_en, wr_en;
  logic signed [15:0] post_trace;
  logic [2:0] rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;
  logic ld_en = 1'b0;
  logic [2:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] mem [N];

  int exp_w [N];
  int exp_a [N];
  int exp_post = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stdp_weight_engine #(.N_PLAST(N), .N_SYN(NS), .WMAX(WMAX), .DPRE(DPRE), .DPOST(DPOST),
    .PRE_SHIFT(PSH), .POST_SHIFT(QSH), .TARGET(TGT)) u_stdp_weight_engine (
    .clk(clk), .rst_n(rst_n), .learn_en(learn_en), .tick(tick), .pre_spike(pre_spike),
    .pre_idx(pre_idx), .post_spike(post_spike), .norm_req(norm_req), .busy(busy),
    .post_trace(post_trace), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
    else if (ld_en) mem[ld_addr] <= ld_data;
  end

  function automatic int clampw(int v);
    return (v < 0) ? 0 : (v > WMAX) ? WMAX : v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_mem(string tag);
    for (int s = 0; s < N; s++) begin
      chk($sformatf("%s w[%0d]", tag, s), int'(mem[s][15:0]), exp_w[s]);
      chk($sformatf("%s a[%0d]", tag, s), int'(mem[s][31:16]), exp_a[s]);
    end
  endtask

  task automatic load(int s, int w, int a);
    @(negedge clk);
    ld_en = 1'b1;  ld_addr = 3'(s);  ld_data = {a[15:0], w[15:0]};
    @(negedge clk);
    ld_en = 1'b0;
    exp_w[s] = w;  exp_a[s] = a;
  endtask

  task automatic issue(bit t, bit nr, bit po, bit pr, int idx, output int cyc);
    @(negedge clk);
    tick = t;  norm_req = nr;  post_spike = po;  pre_spike = pr;  pre_idx = 4'(idx);
    @(negedge clk);
    tick = 0;  norm_req = 0;  post_spike = 0;  pre_spike = 0;
    cyc = 0;
    while (busy && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  function automatic void m_pre(int s);
    exp_w[s] = clampw(exp_w[s] + exp_post);
    exp_a[s] = (exp_a[s] + DPRE > 65535) ? 65535 : exp_a[s] + DPRE;
  endfunction

  function automatic void m_post();
    exp_post = (exp_post + DPOST < -32768) ? -32768 : exp_post + DPOST;
    for (int s = 0; s < N; s++) exp_w[s] = clampw(exp_w[s] + exp_a[s]);
  endfunction

  function automatic void m_decay();
    exp_post = exp_post - (exp_post >>> QSH);
    for (int s = 0; s < N; s++) exp_a[s] = exp_a[s] - (exp_a[s] >> PSH);
  endfunction

  function automatic void m_norm();
    int sum = 0;
    int fac;
    for (int s = 0; s < N; s++) sum += exp_w[s];
    fac = (TGT - sum) / N;
    for (int s = 0; s < N; s++) exp_w[s] = clampw(exp_w[s] + fac);
  endfunction

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++;  n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 post_trace after reset", int'(post_trace), 0);
    chk("R1 no access while idle", int'(rd_en | wr_en), 0);

    for (int s = 0; s < N; s++) load(s, 100 * s + 50, 0);

    // R2: pre spikes with zero post trace
    for (int s = 0; s < N; s++) begin
      issue(0, 0, 0, 1, s, cyc);
      m_pre(s);
      if (s == 0) chk("R2 busy cycles", cyc, 2);
    end
    check_mem("R2 pre sweep");

    // R3: post spike potentiates by pre trace
    issue(0, 0, 1, 0, 0, cyc);
    m_post();
    chk("R3 busy cycles", cyc, N + 1);
    chk("R3 post_trace", int'(post_trace), exp_post);
    check_mem("R3 post");

    // R4: clamp low via pre spike, clamp high via post spike
    load(2, 30, 0);
    issue(0, 0, 0, 1, 2, cyc);
    m_pre(2);
    chk("R4 clamp at zero", int'(mem[2][15:0]), exp_w[2]);
    load(7, 990, 500);
    issue(0, 0, 1, 0, 0, cyc);
    m_post();
    check_mem("R4 clamp at max");

    // R2: trace saturation at maximum
    load(5, 400, 65500);
    issue(0, 0, 0, 1, 5, cyc);
    m_pre(5);
    check_mem("R2 trace saturate");

    // R5: decay tick
    for (int s = 0; s < N; s++) load(s, 200 + 10 * s, 37 * s + 9);
    issue(1, 0, 0, 0, 0, cyc);
    m_decay();
    chk("R5 busy cycles", cyc, N + 1);
    chk("R5 post_trace decay", int'(post_trace), exp_post);
    check_mem("R5 decay");

    // R8: teacher indices ignored
    for (int t = N; t < NS; t++) begin
      issue(0, 0, 0, 1, t, cyc);
      chk($sformatf("R8 teacher %0d busy", t), cyc, 0);
    end
    check_mem("R8 teacher");

    // R7: learning disabled
    learn_en = 1'b0;
    issue(0, 0, 0, 1, 1, cyc);
    chk("R7 pre ignored", cyc, 0);
    issue(0, 0, 1, 0, 0, cyc);
    chk("R7 post ignored", cyc, 0);
    issue(0, 1, 0, 0, 0, cyc);
    chk("R7 norm ignored", cyc, 0);
    chk("R7 post_trace kept", int'(post_trace), exp_post);
    check_mem("R7 gated");
    issue(1, 0, 0, 0, 0, cyc);
    m_decay();
    chk("R5 tick without learn", cyc, N + 1);
    check_mem("R5 tick without learn");
    learn_en = 1'b1;

    // R6: normalization, several sums
    for (int s = 0; s < N; s++) load(s, 100 + 20 * s, 11 * s);
    issue(0, 1, 0, 0, 0, cyc);
    m_norm();
    chk("R6 busy cycles", cyc, 2 * N + 2 + SWB);
    check_mem("R6 norm raise");
    for (int s = 0; s < N; s++) load(s, 900, s);
    issue(0, 1, 0, 0, 0, cyc);
    m_norm();
    check_mem("R6 norm lower");
    for (int s = 0; s < N; s++) load(s, (s < 4) ? 1000 : 5, 0);
    issue(0, 1, 0, 0, 0, cyc);
    m_norm();
    check_mem("R6 norm truncate");
    for (int s = 0; s < N; s++) load(s, (s < 5) ? 1000 : 0, 0);
    issue(0, 1, 0, 0, 0, cyc);
    m_norm();
    check_mem("R6 norm clamp");

    // R9: priority
    for (int s = 0; s < N; s++) load(s, 300 + s, 50 + s);
    issue(1, 0, 1, 1, 0, cyc);
    m_decay();
    chk("R9 tick wins", cyc, N + 1);
    chk("R9 post_trace tick wins", int'(post_trace), exp_post);
    check_mem("R9 tick wins");
    issue(0, 1, 1, 1, 0, cyc);
    m_norm();
    chk("R9 norm wins", cyc, 2 * N + 2 + SWB);
    chk("R9 post_trace norm wins", int'(post_trace), exp_post);
    check_mem("R9 norm wins");

    // R9: request while busy dropped
    @(negedge clk);
    post_spike = 1'b1;
    @(negedge clk);
    post_spike = 1'b0;  pre_spike = 1'b1;  pre_idx = 4'd0;
    @(negedge clk);
    pre_spike = 1'b0;
    while (busy) @(negedge clk);
    m_post();
    chk("R9 busy drop post_trace", int'(post_trace), exp_post);
    check_mem("R9 busy drop");

    // R3: post trace saturation
    for (int k = 0; k < 560; k++) begin
      issue(0, 0, 1, 0, 0, cyc);
      m_post();
    end
    chk("R3 post_trace saturate", int'(post_trace), exp_post);
    chk("R3 post_trace floor", exp_post, -32768);
    check_mem("R3 after many posts");

    // R10: pre spike depresses a single word in place
    load(4, 700, 20);
    issue(0, 0, 0, 1, 4, cyc);
    m_pre(4);
    check_mem("R10 single word");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule